// File: doc/BRIEF.md
# Iterative Integer Divide and Remainder Unit

This unit computes the quotient or the remainder of two integers, one quotient bit per clock, for both a narrow word width and the full register width. Each width works signed or unsigned. It also has an extended quotient mode: the first operand is scaled up by the operand width before dividing, and the result is valid only when the quotient still fits in that width. The unit is driven by a start pulse and answers with a one-cycle done pulse. The result, an overflow flag and three record condition bits stay on the outputs until the next operation completes.

The operands are checked before any iteration begins. The checks cover a zero divisor, the most negative value divided by minus one, and an extended quotient that cannot fit. Such a case is flagged as overflow and returns a zero result at once. Signed operands are divided as magnitudes, and the signs are applied in a fix-up cycle afterwards. The controller has four states: S_IDLE, S_RUN, S_FIX and S_DONE. It has six transitions:
- IDLE-to-DONE when an accepted operation is flagged.
- IDLE-to-RUN when an accepted operation is computed.
- RUN-to-RUN while quotient bits remain.
- RUN-to-FIX after the last bit.
- FIX-to-DONE.
- DONE-to-IDLE.

Top module: `div_unit`

## Requirements
- R1: After reset, busy, done and ovf are 0, result is all zeros and cond is 3'b000.
- R2: start is accepted only on an edge where busy is 0. A start raised while busy is 1 has no effect on the running operation's result or timing. Outside the done cycle, result holds its value.
- R3: Let N be WLEN for word forms (op_word=1) and XLEN otherwise. For a flagged case, done is high in the cycle just after the accepting edge. For any other case, done goes high N+1 edges after the accepting edge. done lasts one cycle, and busy stays 1 from the accepting edge through the done cycle.
- R4: Unsigned quotient (op_kind=2'b00) and unsigned remainder (op_kind=2'b01) return the floor quotient and the remainder. ovf is set only for a zero divisor.
- R5: The signed quotient truncates toward zero. ovf is set for a zero divisor, or for the most negative N-bit value divided by all ones.
- R6: The signed remainder takes the sign of the dividend, and a·b-quotient identity holds. Overflow cases are the same as in R5.
- R7: Word forms use only bits WLEN-1:0 of both operands. For signed forms, result bits above WLEN-1 copy bit WLEN-1; for unsigned forms, they are zero.
- R8: The unsigned extended quotient (op_kind bit 1 set) is (a·2^N)/b. It is flagged when b is 0 or when a ≥ b, because the quotient would not fit in N bits.
- R9: The signed extended quotient is (a·2^N)/b with a signed divisor, truncated. It is flagged before iterating when b is 0 or |a| ≥ |b|. It is flagged after iterating when the quotient lies outside the signed N-bit range.
- R10: On any overflow, result is 0 and cond is 3'b001.
- R11: cond encodes the XLEN-bit result read as a signed value: bit 2 means negative, bit 1 means positive, bit 0 means zero. Exactly one bit is set after each operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new operation |
| op_word | input | 1 | 1 selects the WLEN-bit form |
| op_signed | input | 1 | 1 treats operands as two's complement |
| op_kind | input | 2 | 00 quotient, 01 remainder, 1x extended quotient |
| opnd_a | input | XLEN | Dividend operand |
| opnd_b | input | XLEN | Divisor operand |
| busy | output | 1 | Operation in progress (S_RUN, S_FIX, S_DONE) |
| done | output | 1 | One-cycle completion pulse |
| result | output | XLEN | Quotient or remainder |
| ovf | output | 1 | Undefined case flagged |
| cond | output | 3 | Negative / positive / zero record bits |

## Verification
The bench builds the unit with XLEN=8 and WLEN=4. At that size, every pair of word operands can be swept for each signedness and each kind. The full-width forms are swept over a stride of dividends plus the extreme values, against sixteen chosen divisors. Expected quotients, remainders, fit limits and latencies come from integer arithmetic in the bench. Together they cover every flagged case, including a signed extended quotient that fails only after iterating, and both latencies.

// File: rtl/div_pkg.sv
`timescale 1ns/1ps
package div_pkg;
    typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIX, S_DONE} div_state_e;

    typedef struct packed {
        logic word;
        logic sgn;
        logic ext;
        logic rem;
    } div_op_t;
endpackage

// File: rtl/div_precheck.sv
`timescale 1ns/1ps
module div_precheck import div_pkg::*; #(
    parameter int XLEN = 64,
    parameter int WLEN = 32
) (
    input  div_op_t          op,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    output logic [XLEN-1:0]  mag_a,
    output logic [XLEN-1:0]  mag_b,
    output logic             a_neg,
    output logic             b_neg,
    output logic             ovf_pre
);
    localparam int HI = XLEN - WLEN;

    logic [XLEN-1:0] a_op, b_op;
    logic            a_min, b_ones, b_zero, min_by_m1, ext_big;

    always_comb begin
        // Operands as XLEN-bit two's complement values of the chosen width
        if (op.word) begin
            a_op = op.sgn ? {{HI{a[WLEN-1]}}, a[WLEN-1:0]} : {{HI{1'b0}}, a[WLEN-1:0]};
            b_op = op.sgn ? {{HI{b[WLEN-1]}}, b[WLEN-1:0]} : {{HI{1'b0}}, b[WLEN-1:0]};
            a_neg  = op.sgn & a[WLEN-1];
            b_neg  = op.sgn & b[WLEN-1];
            a_min  = (a[WLEN-1:0] == {1'b1, {(WLEN-1){1'b0}}});
            b_ones = &b[WLEN-1:0];
        end else begin
            a_op = a;
            b_op = b;
            a_neg  = op.sgn & a[XLEN-1];
            b_neg  = op.sgn & b[XLEN-1];
            a_min  = (a == {1'b1, {(XLEN-1){1'b0}}});
            b_ones = &b;
        end
        mag_a = a_neg ? (~a_op + 1'b1) : a_op;
        mag_b = b_neg ? (~b_op + 1'b1) : b_op;

        b_zero    = (b_op == '0);
        min_by_m1 = op.sgn & ~op.ext & a_min & b_ones;
        // A scaled dividend whose high half is not below the divisor cannot fit
        ext_big   = op.ext & (mag_a >= mag_b);
        ovf_pre   = b_zero | min_by_m1 | ext_big;
    end
endmodule

// File: rtl/div_core.sv
`timescale 1ns/1ps
module div_core #(
    parameter int XLEN = 64,
    parameter int CW   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [XLEN-1:0]  rem_init,
    input  logic [XLEN-1:0]  shr_init,
    input  logic [XLEN-1:0]  dvs_init,
    input  logic [CW-1:0]    iters_m1,
    output logic [XLEN-1:0]  quo,
    output logic [XLEN-1:0]  rem,
    output logic             last
);
    logic [XLEN-1:0] rem_q, shr_q, dvs_q;
    logic [CW-1:0]   cnt_q;
    logic [XLEN:0]   widened, trial;
    logic            fits;

    always_comb begin
        widened = {rem_q, shr_q[XLEN-1]};
        trial   = widened - {1'b0, dvs_q};
        fits    = (widened >= {1'b0, dvs_q});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            shr_q <= '0;
            dvs_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            rem_q <= rem_init;
            shr_q <= shr_init;
            dvs_q <= dvs_init;
            cnt_q <= iters_m1;
        end else if (step) begin
            rem_q <= fits ? trial[XLEN-1:0] : widened[XLEN-1:0];
            shr_q <= {shr_q[XLEN-2:0], fits};
            if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        end
    end

    assign quo  = shr_q;
    assign rem  = rem_q;
    assign last = (cnt_q == '0);
endmodule

// File: rtl/div_post.sv
`timescale 1ns/1ps
module div_post import div_pkg::*; #(
    parameter int XLEN = 64,
    parameter int WLEN = 32
) (
    input  div_op_t          op,
    input  logic             neg_q,
    input  logic             neg_r,
    input  logic [XLEN-1:0]  quo,
    input  logic [XLEN-1:0]  rem,
    output logic [XLEN-1:0]  res,
    output logic             ovf_late,
    output logic [2:0]       cond
);
    localparam int HI = XLEN - WLEN;

    logic [XLEN-1:0] mag, val, shaped;
    logic            neg, top_bit, rest_zero;

    always_comb begin
        mag = op.rem ? rem : quo;
        neg = op.rem ? neg_r : neg_q;
        val = neg ? (~mag + 1'b1) : mag;

        if (op.word) begin
            shaped    = op.sgn ? {{HI{val[WLEN-1]}}, val[WLEN-1:0]} : {{HI{1'b0}}, val[WLEN-1:0]};
            top_bit   = mag[WLEN-1];
            rest_zero = (mag[WLEN-2:0] == '0);
        end else begin
            shaped    = val;
            top_bit   = mag[XLEN-1];
            rest_zero = (mag[XLEN-2:0] == '0);
        end

        // Signed scaled quotient: magnitude 2^(N-1) is only legal when negative
        ovf_late = op.ext & op.sgn & top_bit & ~(neg_q & rest_zero);
        res      = ovf_late ? '0 : shaped;

        cond[2] = res[XLEN-1];
        cond[0] = (res == '0);
        cond[1] = ~cond[2] & ~cond[0];
    end
endmodule

// File: rtl/div_unit.sv
`timescale 1ns/1ps
module div_unit import div_pkg::*; #(
    parameter int XLEN = 64,
    parameter int WLEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             op_word,
    input  logic             op_signed,
    input  logic [1:0]       op_kind,
    input  logic [XLEN-1:0]  opnd_a,
    input  logic [XLEN-1:0]  opnd_b,
    output logic             busy,
    output logic             done,
    output logic [XLEN-1:0]  result,
    output logic             ovf,
    output logic [2:0]       cond
);
    localparam int CW = $clog2(XLEN + 1);
    localparam int HI = XLEN - WLEN;
    localparam logic [CW-1:0] ITER_W = CW'(WLEN - 1);
    localparam logic [CW-1:0] ITER_X = CW'(XLEN - 1);

    div_state_e      state_q, state_d;
    div_op_t         op_in, op_q;
    logic            neg_q_q, neg_r_q;
    logic            accept;
    logic [XLEN-1:0] mag_a, mag_b;
    logic            a_neg, b_neg, ovf_pre;
    logic [XLEN-1:0] rem_init, shr_init, quo, rem;
    logic            last;
    logic [XLEN-1:0] post_res;
    logic            post_ovf;
    logic [2:0]      post_cond;
    logic            lat_word, lat_sgn;

    always_comb begin
        op_in.word = op_word;
        op_in.sgn  = op_signed;
        op_in.ext  = op_kind[1];
        op_in.rem  = ~op_kind[1] & op_kind[0];
    end

    assign accept = start && (state_q == S_IDLE);

    div_precheck #(.XLEN(XLEN), .WLEN(WLEN)) u_pre (
        .op      (op_in),
        .a       (opnd_a),
        .b       (opnd_b),
        .mag_a   (mag_a),
        .mag_b   (mag_b),
        .a_neg   (a_neg),
        .b_neg   (b_neg),
        .ovf_pre (ovf_pre)
    );

    // Plain forms shift the dividend through from the top; scaled forms start
    // with the dividend already in the partial remainder.
    always_comb begin
        if (op_in.ext) begin
            rem_init = mag_a;
            shr_init = '0;
        end else begin
            rem_init = '0;
            shr_init = op_in.word ? {mag_a[WLEN-1:0], {HI{1'b0}}} : mag_a;
        end
    end

    div_core #(.XLEN(XLEN), .CW(CW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept && !ovf_pre),
        .step     (state_q == S_RUN),
        .rem_init (rem_init),
        .shr_init (shr_init),
        .dvs_init (mag_b),
        .iters_m1 (op_in.word ? ITER_W : ITER_X),
        .quo      (quo),
        .rem      (rem),
        .last     (last)
    );

    div_post #(.XLEN(XLEN), .WLEN(WLEN)) u_post (
        .op       (op_q),
        .neg_q    (neg_q_q),
        .neg_r    (neg_r_q),
        .quo      (quo),
        .rem      (rem),
        .res      (post_res),
        .ovf_late (post_ovf),
        .cond     (post_cond)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = ovf_pre ? S_DONE : S_RUN;
            S_RUN:   if (last)  state_d = S_FIX;
            S_FIX:   state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs and operation context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= '0;
            neg_q_q <= 1'b0;
            neg_r_q <= 1'b0;
            result  <= '0;
            ovf     <= 1'b0;
            cond    <= 3'b000;
        end else if (accept) begin
            op_q    <= op_in;
            neg_q_q <= a_neg ^ b_neg;
            neg_r_q <= a_neg;
            if (ovf_pre) begin
                result <= '0;
                ovf    <= 1'b1;
                cond   <= 3'b001;
            end
        end else if (state_q == S_FIX) begin
            result <= post_res;
            ovf    <= post_ovf;
            cond   <= post_cond;
        end
    end

    assign busy     = (state_q != S_IDLE);
    assign done     = (state_q == S_DONE);
    assign lat_word = op_q.word;
    assign lat_sgn  = op_q.sgn;
endmodule

// File: rtl/div_unit_chk.sv
`timescale 1ns/1ps
module div_unit_chk #(
    parameter int XLEN = 64,
    parameter int WLEN = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             op_word,
    input logic             busy,
    input logic             done,
    input logic [XLEN-1:0]  result,
    input logic             ovf,
    input logic [2:0]       cond,
    input logic             lat_word,
    input logic             lat_sgn
);
    localparam int CW2 = $clog2(XLEN + 4);
    localparam logic [CW2-1:0] LIM_W = CW2'(WLEN + 2);
    localparam logic [CW2-1:0] LIM_X = CW2'(XLEN + 2);

    logic [CW2-1:0] since_q;
    logic           word_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '0;
            word_q  <= 1'b0;
        end else if (start && !busy) begin
            since_q <= CW2'(1);
            word_q  <= op_word;
        end else if (busy && since_q != '1) begin
            since_q <= since_q + 1'b1;
        end
    end

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    busy_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R3
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (since_q == CW2'(1) || since_q == (word_q ? LIM_W : LIM_X)));

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R2
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> (done || $stable(result)));

    // R10
    ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ovf) |-> (result == '0 && cond == 3'b001));

    // R11
    cond_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones(cond) == 1));

    // R7
    word_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ovf && lat_word) |->
        (result[XLEN-1:WLEN] == (lat_sgn ? {(XLEN-WLEN){result[WLEN-1]}} : '0)));
endmodule

bind div_unit div_unit_chk #(.XLEN(XLEN), .WLEN(WLEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op_word  (op_word),
    .busy     (busy),
    .done     (done),
    .result   (result),
    .ovf      (ovf),
    .cond     (cond),
    .lat_word (lat_word),
    .lat_sgn  (lat_sgn)
);

// File: tb/tb_div_unit.sv
`timescale 1ns/1ps
module tb_div_unit;
    localparam int X = 8;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         op_word = 1'b0;
    logic         op_signed = 1'b0;
    logic [1:0]   op_kind = 2'b00;
    logic [X-1:0] opnd_a = '0;
    logic [X-1:0] opnd_b = '0;
    logic         busy, done, ovf;
    logic [X-1:0] result;
    logic [2:0]   cond;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    div_unit #(.XLEN(X), .WLEN(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_word(op_word),
        .op_signed(op_signed), .op_kind(op_kind), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .busy(busy), .done(done), .result(result),
        .ovf(ovf), .cond(cond)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Arithmetic model from the requirements
    function automatic void model(input bit word, input bit sgn, input bit [1:0] kind,
                                  input longint a, input longint b,
                                  output bit exp_ovf, output longint v, output int lat);
        int     n;
        longint m, av, bv, sa, sb, q, absa, absb;
        bit     ext, remf, pre;
        n  = word ? W : X;
        m  = longint'(1) << n;
        av = a & (m - 1);
        bv = b & (m - 1);
        sa = (sgn && av >= m / 2) ? av - m : av;
        sb = (sgn && bv >= m / 2) ? bv - m : bv;
        ext  = kind[1];
        remf = !kind[1] && kind[0];
        absa = (sa < 0) ? -sa : sa;
        absb = (sb < 0) ? -sb : sb;
        pre = (bv == 0) || (sgn && !ext && sa == -(m / 2) && sb == -1) || (ext && absa >= absb);
        v = 0;
        exp_ovf = 1'b0;
        if (pre) begin
            exp_ovf = 1'b1;
            lat = 1;
        end else begin
            lat = n + 2;
            if (ext) begin
                q = (sa * m) / sb;
                exp_ovf = sgn ? !(q >= -(m / 2) && q < m / 2) : !(q < m);
                v = exp_ovf ? 0 : q;
            end else begin
                v = remf ? (sa % sb) : (sa / sb);
            end
        end
    endfunction

    function automatic longint pick_b(input int j);
        case (j)
            0: return 0;     1: return 1;     2: return 2;     3: return 3;
            4: return 7;     5: return 16;    6: return 37;    7: return 127;
            8: return 128;   9: return 129;   10: return 200;  11: return 254;
            12: return 255;  13: return 5;    14: return 64;   default: return 250;
        endcase
    endfunction

    function automatic longint pick_a(input int i);
        if (i < 40) return longint'((i * 37) & 255);
        case (i)
            40: return 128;  41: return 127;  42: return 255;  43: return 1;
            default: return 129;
        endcase
    endfunction

    task automatic run_op(input bit word, input bit sgn, input bit [1:0] kind,
                          input longint a, input longint b, input bit poke);
        bit     eovf;
        longint v;
        int     elat, lat;
        bit     seen;
        logic [X-1:0] er;
        logic [2:0]   ec;
        string tag;
        model(word, sgn, kind, a, b, eovf, v, elat);
        er = v[X-1:0];
        ec = (er == '0) ? 3'b001 : (er[X-1] ? 3'b100 : 3'b010);
        if (kind[1]) tag = sgn ? "R9" : "R8";
        else if (sgn) tag = kind[0] ? "R6" : "R5";
        else tag = "R4";

        @(negedge clk);
        op_word = word; op_signed = sgn; op_kind = kind;
        opnd_a = a[X-1:0]; opnd_b = b[X-1:0];
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        lat = 0;
        seen = 1'b0;
        while (!seen && lat < 300) begin
            @(negedge clk);
            lat++;
            if (lat == 1) chk(busy === 1'b1, "R3 busy", longint'(busy), 1);
            if (poke && lat == 2) begin
                // R2: start while busy, with a zero divisor, must be ignored
                start = 1'b1; opnd_b = '0; opnd_a = 8'h55;
            end
            if (poke && lat == 3) start = 1'b0;
            if (done === 1'b1) seen = 1'b1;
        end
        chk(lat == elat, poke ? "R2 latency" : "R3 latency", lat, elat);
        chk(ovf === eovf, tag, longint'(ovf), longint'(eovf));
        if (eovf) begin
            chk(result === '0 && cond === 3'b001, "R10", longint'(result), 0);
        end else begin
            chk(result === er, poke ? "R2 result" : tag, longint'(result), longint'(er));
            chk(cond === ec, "R11", longint'(cond), longint'(ec));
            if (word)
                chk(result[X-1:W] === er[X-1:W], "R7", longint'(result[X-1:W]), longint'(er[X-1:W]));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(busy === 1'b0 && done === 1'b0 && ovf === 1'b0, "R1 flags",
            longint'({busy, done, ovf}), 0);
        chk(result === '0 && cond === 3'b000, "R1 outputs", longint'(result), 0);

        // R2: ignored start while busy
        run_op(1'b0, 1'b0, 2'b00, 200, 7, 1'b1);

        // Word forms, every operand pair (R7 upper half included)
        for (int s = 0; s < 2; s++)
            for (int k = 0; k < 3; k++)
                for (int a = 0; a < 16; a++)
                    for (int b = 0; b < 16; b++)
                        run_op(1'b1, s[0], k[1:0], longint'(a) | 64'hA0, longint'(b) | 64'h50, 1'b0);

        // Full-width forms over a dividend stride and chosen divisors
        for (int s = 0; s < 2; s++)
            for (int k = 0; k < 3; k++)
                for (int i = 0; i < 45; i++)
                    for (int j = 0; j < 16; j++)
                        run_op(1'b0, s[0], k[1:0], pick_a(i), pick_b(j), 1'b0);

        // Extended encoding with bit 0 set behaves as extended (R8)
        run_op(1'b0, 1'b0, 2'b11, 3, 10, 1'b0);

        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog act=0 exp=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule